// File: doc/BRIEF.md
# Return-Address Stack with Fault Detection

This block is the hardware return-address stack of a small 8-bit processor core. When the core performs a call or takes an interrupt, it pushes the current program-counter value. A return pops it. The most recent entry is always visible on the top-of-stack output, so the core can load it into its program counter without waiting an extra cycle.

A plain stack would wrap or silently drop an operation that goes past its ends. This block detects both cases instead. A push while every entry is occupied is an overflow, and a pop while nothing is stored is an underflow. Each one sets its own sticky flag. A configuration bit lets either fault also send a one-cycle reset request to the device reset controller. Software clears the flags with a clear strobe.

Push and pop are single-cycle strobes with no back-pressure. The stack accepts an operation on every clock edge, so the interface has no ready signal.

Top module: `ras_fault_stack`

## Requirements
- R1: After reset, the stack is empty, both flags and the reset request are low, and the top-of-stack output reads zero.
- R2: A push stores the data word, and the top-of-stack output shows it after the clock edge that accepts it. Pops then return the stored words in reverse order of pushing, one per edge.
- R3: The stack holds DEPTH (16) words of PC_W (15) bits. A push-only strobe while all DEPTH entries are used sets the overflow flag after that edge.
- R4: A push on a full stack overwrites the top entry and leaves the occupancy unchanged. The next pop therefore exposes the entry that was second from the top before the overflow.
- R5: A pop-only strobe on an empty stack sets the underflow flag and leaves the stack empty. While the stack is empty, the top-of-stack output reads entry zero.
- R6: Both flags are sticky and drop only on reset or on the clear strobe, which clears both flags together. If a fault occurs in the same cycle as a clear, the fault's flag ends set.
- R7: Push and pop in the same cycle replace the top entry (entry zero when the stack is empty). The occupancy does not change and no fault is raised, even when the stack is full or empty.
- R8: With the reset-on-fault bit set, the reset request is high for exactly the one cycle after each faulting edge. With the bit clear, the request stays low, and the stack and flags behave exactly as described in the other requirements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_fault_rst_en | input | 1 | When 1, an overflow or underflow raises the reset request |
| push_en | input | 1 | Push strobe |
| pop_en | input | 1 | Pop strobe |
| push_pc | input | PC_W | Word stored by a push |
| flag_clr | input | 1 | Clears both sticky flags |
| tos_pc | output | PC_W | Current top-of-stack word |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| rst_req | output | 1 | One-cycle reset request after a fault |

## Verification
The hardest states to reach are the ones at the full boundary. Only the seventeenth consecutive push reaches the overflow overwrite, and a combined push and pop on a full stack must produce no fault. To reach them, the stimulus fills the stack to every level from zero to DEPTH and then pushes once more. It then drains the stack and pops once past empty. This sweep runs with the reset-on-fault bit both clear and set. Directed sequences then place a combined push and pop on the full and empty stack, and a clear strobe in the same cycle as a fault.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;

  function automatic ras_op_e decode_op(input logic push, input logic pop);
    return ras_op_e'({pop, push});
  endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ras_op_e          op,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             ovf_evt,
  output logic             unf_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty;
  logic [CNT_W-1:0] cnt_m1;
  logic [IDX_W-1:0] top_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign cnt_m1  = cnt_q - CNT_W'(1);
  assign top_idx = empty ? '0 : cnt_m1[IDX_W-1:0];
  assign rd_idx  = top_idx;

  always_comb begin
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    wr_idx  = top_idx;
    ovf_evt = 1'b0;
    unf_evt = 1'b0;
    unique case (op)
      OP_PUSH: begin
        wr_en = 1'b1;
        if (full) begin
          ovf_evt = 1'b1;
        end else begin
          wr_idx = cnt_q[IDX_W-1:0];
          cnt_d  = cnt_q + CNT_W'(1);
        end
      end
      OP_POP: begin
        if (empty) unf_evt = 1'b1;
        else       cnt_d   = cnt_m1;
      end
      OP_SWAP: wr_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: occupancy never exceeds capacity
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R4: push on a full stack keeps occupancy
  a_r4_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && full) |=> (cnt_q == CNT_W'(DEPTH)));

  // R2: push below capacity grows occupancy by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R5: pop on an empty stack stays empty
  a_r5_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && empty) |=> (cnt_q == '0));

  // R7: combined push and pop keeps occupancy
  a_r7_swap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SWAP) |=> $stable(cnt_q));

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 15,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_data
);

  logic [PC_W-1:0] entry_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[gi] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(gi)))
        entry_q[gi] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_idx];

  // R2: a written word lands in the addressed entry
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entry_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/ras_fault_flags.sv
module ras_fault_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic unf_evt,
  input  logic clr,
  input  logic rst_en,
  output logic ovf_flag,
  output logic unf_flag,
  output logic rst_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      ovf_flag <= ovf_evt | (ovf_flag & ~clr);
      unf_flag <= unf_evt | (unf_flag & ~clr);
      rst_req  <= rst_en & (ovf_evt | unf_evt);
    end
  end

  // R3: overflow event sets the flag
  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  // R6: flags hold without a clear
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr) |=> ovf_flag);
  a_r6_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !clr) |=> unf_flag);

  // R8: request follows an enabled fault, and only then
  a_r8_req_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_en && (ovf_evt || unf_evt)) |=> rst_req);
  a_r8_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rst_en && (ovf_evt || unf_evt)));

endmodule

// File: rtl/ras_fault_stack.sv
module ras_fault_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_fault_rst_en,
  input  logic            push_en,
  input  logic            pop_en,
  input  logic [PC_W-1:0] push_pc,
  input  logic            flag_clr,
  output logic [PC_W-1:0] tos_pc,
  output logic            ovf_flag,
  output logic            unf_flag,
  output logic            rst_req
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ras_op_e          op;
  logic             wr_en, ovf_evt, unf_evt;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign op = decode_op(push_en, pop_en);

  ras_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk(clk), .rst_n(rst_n), .op(op),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(push_pc),
    .rd_idx(rd_idx), .rd_data(tos_pc)
  );

  ras_fault_flags i_flags (
    .clk(clk), .rst_n(rst_n),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .clr(flag_clr), .rst_en(cfg_fault_rst_en),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req)
  );

  // R7: combined push and pop never raises a fault
  a_r7_swap_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en) |-> !(ovf_evt || unf_evt));

endmodule

// File: tb/test_ras_fault_stack.sv
module test_ras_fault_stack;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PC_W  = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, push_en = 1'b0, pop_en = 1'b0, flag_clr = 1'b0;
  logic [PC_W-1:0] push_pc = '0;
  logic [PC_W-1:0] tos_pc;
  logic ovf_flag, unf_flag, rst_req;

  int n_checks = 0, n_fail = 0, cycles = 0;

  logic [PC_W-1:0] m [DEPTH];
  int  cnt = 0;
  bit  e_ovf = 0, e_unf = 0, e_req = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_fault_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) i_ras_fault_stack (
    .clk(clk), .rst_n(rst_n), .cfg_fault_rst_en(cfg_en),
    .push_en(push_en), .pop_en(pop_en), .push_pc(push_pc),
    .flag_clr(flag_clr), .tos_pc(tos_pc),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] pat(int k);
    return PC_W'((k * 32'h2F3 + 5) & 32'h7FFF);
  endfunction

  task automatic check_all(string tag);
    chk(tag, "tos_pc", int'(tos_pc), int'((cnt == 0) ? m[0] : m[cnt-1]));
    chk((tag == "R6") ? "R6" : "R3", "ovf_flag", int'(ovf_flag), int'(e_ovf));
    chk((tag == "R6") ? "R6" : "R5", "unf_flag", int'(unf_flag), int'(e_unf));
    chk("R8", "rst_req", int'(rst_req), int'(e_req));
  endtask

  // drive one cycle at negedge, update model, check at next negedge
  task automatic op(bit push, bit pop, logic [PC_W-1:0] d, bit clr);
    bit fo, fu;
    string tag;
    fo = push && !pop && cnt == DEPTH;
    fu = pop && !push && cnt == 0;
    tag = fo ? "R4" : (push && pop) ? "R7" : fu ? "R5" : clr ? "R6" : "R2";
    push_en = push; pop_en = pop; push_pc = d; flag_clr = clr;
    if (push && pop)      m[(cnt == 0) ? 0 : cnt-1] = d;
    else if (push) begin
      if (cnt < DEPTH) begin m[cnt] = d; cnt++; end
      else m[DEPTH-1] = d;
    end else if (pop && cnt > 0) cnt--;
    e_ovf = fo || (e_ovf && !clr);
    e_unf = fu || (e_unf && !clr);
    e_req = cfg_en && (fo || fu);
    @(posedge clk);
    @(negedge clk);
    push_en = 0; pop_en = 0; flag_clr = 0;
    check_all(tag);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < DEPTH; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");  // R1 reset state

    // sweep every fill level with reset option off and on (R2 R3 R4 R5 R8)
    for (int en = 0; en < 2; en++) begin
      cfg_en = en[0];
      for (int n = 0; n <= DEPTH; n++) begin
        op(0, 0, '0, 1);
        for (int k = 0; k < n; k++) op(1, 0, pat(n * 40 + k), 0);
        op(1, 0, pat(n * 40 + 39), 0);
        for (int k = 0; k <= n; k++) op(0, 1, '0, 0);
        op(0, 1, '0, 0);
        op(0, 0, '0, 0);
      end
    end

    // R7: combined push and pop on empty and full stacks
    cfg_en = 1;
    op(0, 0, '0, 1);
    op(1, 1, 15'h1234, 0);
    for (int k = 0; k < DEPTH; k++) op(1, 0, pat(900 + k), 0);
    op(1, 1, 15'h4321, 0);
    op(0, 1, '0, 0);
    op(1, 1, 15'h0ABC, 0);

    // R6: clear colliding with faults, then a plain clear
    for (int k = 0; k < DEPTH; k++) op(1, 0, pat(700 + k), 0);
    op(1, 0, 15'h7FFF, 1);
    op(0, 0, '0, 1);
    for (int k = 0; k < DEPTH; k++) op(0, 1, '0, 0);
    op(0, 1, '0, 1);
    op(0, 1, '0, 0);
    op(0, 0, '0, 1);
    op(0, 0, '0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule